// File: doc/BRIEF.md
# Multichannel SAR Converter Sequencer

This block is the digital half of an eight-input, 12-bit successive-approximation converter. Software programs it through a 32-bit register port with an address, a write enable, write data and combinational read data. It chooses channels with a bitmap, sets a sampling length and starts a scan. The analog input multiplexer, the sample-and-hold, the DAC and the comparator stay outside. The block drives the channel select, the sample strobe and the DAC trial code, and it reads back the comparator decision.

For each selected channel, taken in ascending index order, the sequencer holds the sample strobe high for the programmed number of clocks. It then runs a 12-step binary search at one trial bit per clock, most significant bit first. It stores the code in that channel's data register and raises the channel's completion flag. A single scan clears the enable once it ends. A repeating scan starts again from the lowest selected channel until software clears the enable. Completion flags and a channel-select-error flag are cleared by writing ones. An interrupt output can show them as a level or as one-cycle pulses.

Top module: `sar_seq_top`

## Requirements
- R1: After reset, control word 0 (0x00) reads 0, control word 3 (0x0C) reads 0x000E0578, the divider word (0x28) reads 4, the status word (0x24) reads 0, every data word reads 0 and `irq` is low.
- R2: Control word 0 holds enable in bit 0, busy (read-only) in bit 1, power-up in bit 2 and reset release in bit 15. While power-up or reset release reads 0, a write that sets the enable is ignored and the status word is held at 0. A write that powers the block up does not itself start a scan.
- R3: Each converted channel n stores the largest 12-bit code c for which the comparator reported input >= c. This code is the binary-search result. It is stored in bits 11:0 of the word at 0x30 + 4*n, and the upper bits read 0.
- R4: With the repeat bit (control word 1, bit 8) at 0, the channels set in bits 7:0 of control word 2 (0x08) are converted once each in ascending order. Each one sets its status bit n. The enable then clears itself and busy falls.
- R5: With the repeat bit at 1, the scan wraps to the lowest selected channel and continues while the enable stays set.
- R6: Setting the enable with an all-zero channel bitmap sets status bit 16, leaves the enable at 0 and starts no conversion.
- R7: Writing 1 to a status bit clears it. Writing 0 leaves it unchanged.
- R8: Clearing the enable abandons the conversion in progress. Busy reads 0 one clock after the write. The abandoned channel gets neither a status bit nor a new data value.
- R9: Before each conversion the sample strobe is high for exactly N clocks, where N is bits 15:0 of control word 3. A value of 0 counts as 1.
- R10: The interrupt control word (0x20) holds per-channel enables in bits 7:0, the error enable in bit 16 and the level select in bit 31. In level mode `irq` is high while any enabled status bit is set. In pulse mode each enabled completion or error gives one single-clock pulse.
- R11: The divider word always reads 4. Writes to it have no effect.
- R12: Control word 3 stores bits 23:0 as written, and its bits 31:24 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 8 | Register byte address |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| cmp_in | input | 1 | Comparator: 1 when the sampled input >= DAC code |
| dac_code | output | 12 | Trial code for the external DAC |
| sample_en | output | 1 | Sample-and-hold strobe |
| conv_chan | output | 3 | Analog multiplexer channel select |
| irq | output | 1 | Interrupt request |

## Verification
A wrong trial bit or a bad comparator capture shows up as a data word that differs from the bench's analog value. It is visible as soon as the scan ends. A faulty channel walk shows up right away in the order of channel selects at each rising sample strobe, and as completion flags on channels outside the bitmap. Gating and abort faults show up within one or two clocks: busy, the enable or the status word reads back wrong right after the controlling write.

// File: rtl/sar_pkg.sv
package sar_pkg;
    localparam int ADDR_W = 8;

    localparam logic [ADDR_W-1:0] OFS_CTL0 = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_CTL1 = 8'h04;
    localparam logic [ADDR_W-1:0] OFS_CTL2 = 8'h08;
    localparam logic [ADDR_W-1:0] OFS_CTL3 = 8'h0C;
    localparam logic [ADDR_W-1:0] OFS_INTC = 8'h20;
    localparam logic [ADDR_W-1:0] OFS_STAT = 8'h24;
    localparam logic [ADDR_W-1:0] OFS_DIVR = 8'h28;
    localparam logic [ADDR_W-1:0] OFS_DATA = 8'h30;

    localparam logic [15:0] SAMP_RESET = 16'h0578;
    localparam logic [7:0]  CMP_RESET  = 8'h0E;
    localparam logic [8:0]  DIV_FIXED  = 9'd4;

    typedef enum logic [1:0] {
        ENG_IDLE,
        ENG_SAMPLE,
        ENG_CONV
    } eng_state_e;
endpackage

// File: rtl/sar_engine.sv
module sar_engine
    import sar_pkg::*;
#(
    parameter int NUM_CH   = 8,
    parameter int RES_BITS = 12,
    parameter int SAMP_W   = 16,
    localparam int CH_W    = $clog2(NUM_CH),
    localparam int BIT_W   = $clog2(RES_BITS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic                run_en,
    input  logic [NUM_CH-1:0]   bitmap,
    input  logic                repeat_mode,
    input  logic [SAMP_W-1:0]   samp_len,
    input  logic                cmp_in,
    output logic                busy,
    output logic                sample_en,
    output logic [CH_W-1:0]     chan,
    output logic [RES_BITS-1:0] dac_code,
    output logic                done,
    output logic [CH_W-1:0]     done_ch,
    output logic [RES_BITS-1:0] done_code,
    output logic                scan_end
);
    typedef struct packed {
        eng_state_e           state;
        logic [CH_W-1:0]      ch;
        logic [SAMP_W-1:0]    cnt;
        logic [BIT_W-1:0]     bitn;
        logic [RES_BITS-1:0]  acc;
        logic                 done;
        logic [CH_W-1:0]      dch;
        logic [RES_BITS-1:0]  code;
        logic                 fin;
    } eng_t;

    eng_t eng_d, eng_q;

    function automatic logic [CH_W-1:0] lowest_set(input logic [NUM_CH-1:0] m);
        logic [CH_W-1:0] r = '0;
        for (int i = NUM_CH - 1; i >= 0; i--) begin
            if (m[i]) r = CH_W'(i);
        end
        return r;
    endfunction

    function automatic logic [CH_W:0] next_above(input logic [NUM_CH-1:0] m,
                                                 input logic [CH_W-1:0]   cur);
        logic [CH_W:0] r = '0;
        for (int i = NUM_CH - 1; i >= 0; i--) begin
            if (m[i] && (i > int'(cur))) r = {1'b1, CH_W'(i)};
        end
        return r;
    endfunction

    logic [SAMP_W-1:0]   load_cnt;
    logic [RES_BITS-1:0] trial;
    logic [RES_BITS-1:0] acc_new;
    logic [CH_W:0]       nxt;

    always_comb begin
        load_cnt = (samp_len == '0) ? '0 : samp_len - 1'b1;
        trial    = eng_q.acc | (RES_BITS'(1) << eng_q.bitn);
        acc_new  = cmp_in ? trial : eng_q.acc;
        nxt      = next_above(bitmap, eng_q.ch);

        eng_d      = eng_q;
        eng_d.done = 1'b0;
        eng_d.fin  = 1'b0;

        if (eng_q.state == ENG_IDLE || !run_en) begin
            eng_d.state = ENG_IDLE;
            if (start) begin
                eng_d.state = ENG_SAMPLE;
                eng_d.ch    = lowest_set(bitmap);
                eng_d.cnt   = load_cnt;
            end
        end else if (eng_q.state == ENG_SAMPLE) begin
            if (eng_q.cnt == '0) begin
                eng_d.state = ENG_CONV;
                eng_d.bitn  = BIT_W'(RES_BITS - 1);
                eng_d.acc   = '0;
            end else begin
                eng_d.cnt = eng_q.cnt - 1'b1;
            end
        end else begin
            eng_d.acc = acc_new;
            if (eng_q.bitn == '0) begin
                eng_d.done = 1'b1;
                eng_d.dch  = eng_q.ch;
                eng_d.code = acc_new;
                if (nxt[CH_W]) begin
                    eng_d.state = ENG_SAMPLE;
                    eng_d.ch    = nxt[CH_W-1:0];
                    eng_d.cnt   = load_cnt;
                end else if (repeat_mode && (|bitmap)) begin
                    eng_d.state = ENG_SAMPLE;
                    eng_d.ch    = lowest_set(bitmap);
                    eng_d.cnt   = load_cnt;
                end else begin
                    eng_d.state = ENG_IDLE;
                    eng_d.fin   = 1'b1;
                end
            end else begin
                eng_d.bitn = eng_q.bitn - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            eng_q <= '{state: ENG_IDLE, default: '0};
        end else begin
            eng_q <= eng_d;
        end
    end

    assign busy      = (eng_q.state != ENG_IDLE);
    assign sample_en = (eng_q.state == ENG_SAMPLE);
    assign chan      = eng_q.ch;
    assign dac_code  = (eng_q.state == ENG_CONV) ? trial : '0;
    assign done      = eng_q.done;
    assign done_ch   = eng_q.dch;
    assign done_code = eng_q.code;
    assign scan_end  = eng_q.fin;
endmodule

// File: rtl/sar_regs.sv
module sar_regs
    import sar_pkg::*;
#(
    parameter int NUM_CH   = 8,
    parameter int RES_BITS = 12,
    parameter int SAMP_W   = 16,
    localparam int CH_W    = $clog2(NUM_CH)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   addr,
    input  logic                we,
    input  logic [31:0]         wdata,
    output logic [31:0]         rdata,
    input  logic                eng_busy,
    input  logic                eng_done,
    input  logic [CH_W-1:0]     eng_done_ch,
    input  logic [RES_BITS-1:0] eng_code,
    input  logic                eng_end,
    output logic                run_en,
    output logic                start,
    output logic [NUM_CH-1:0]   bitmap,
    output logic                repeat_mode,
    output logic [SAMP_W-1:0]   samp_len,
    output logic                active,
    output logic [NUM_CH-1:0]   stat_flags,
    output logic                stat_err,
    output logic                irq
);
    typedef struct packed {
        logic                             en;
        logic                             pwr;
        logic                             srst;
        logic                             trg;
        logic                             sel;
        logic                             buf1;
        logic                             rpt;
        logic [1:0]                       edg;
        logic [NUM_CH-1:0]                bmap;
        logic [7:0]                       cmp;
        logic [SAMP_W-1:0]                samp;
        logic [NUM_CH-1:0]                ie;
        logic                             eie;
        logic                             lvl;
        logic [NUM_CH-1:0]                dst;
        logic                             est;
        logic                             irq;
        logic [NUM_CH-1:0][RES_BITS-1:0]  data;
    } regs_t;

    regs_t reg_d, reg_q;

    logic              act_q;
    logic              hold;
    logic              err_set;
    logic              evt;
    logic [ADDR_W-1:0] dofs;
    logic              data_hit;

    // next-state logic for every register
    always_comb begin
        reg_d   = reg_q;
        start   = 1'b0;
        err_set = 1'b0;
        act_q   = reg_q.pwr & reg_q.srst;

        if (we) begin
            case (addr)
                OFS_CTL0: begin
                    reg_d.pwr  = wdata[2];
                    reg_d.srst = wdata[15];
                    if (!wdata[0]) begin
                        reg_d.en = 1'b0;
                    end else if (act_q && wdata[2] && wdata[15]) begin
                        if (|reg_q.bmap) begin
                            reg_d.en = 1'b1;
                            start    = 1'b1;
                        end else begin
                            err_set = 1'b1;
                        end
                    end
                end
                OFS_CTL1: begin
                    reg_d.trg  = wdata[0];
                    reg_d.sel  = wdata[2];
                    reg_d.buf1 = wdata[4];
                    reg_d.rpt  = wdata[8];
                    reg_d.edg  = wdata[13:12];
                end
                OFS_CTL2: reg_d.bmap = wdata[NUM_CH-1:0];
                OFS_CTL3: begin
                    reg_d.cmp  = wdata[23:16];
                    reg_d.samp = wdata[SAMP_W-1:0];
                end
                OFS_INTC: begin
                    reg_d.ie  = wdata[NUM_CH-1:0];
                    reg_d.eie = wdata[16];
                    reg_d.lvl = wdata[31];
                end
                OFS_STAT: begin
                    reg_d.dst = reg_q.dst & ~wdata[NUM_CH-1:0];
                    reg_d.est = reg_q.est & ~wdata[16];
                end
                default: ;
            endcase
        end

        if (eng_end && !start) reg_d.en = 1'b0;
        if (eng_done) begin
            reg_d.data[eng_done_ch] = eng_code;
            reg_d.dst[eng_done_ch]  = 1'b1;
        end
        if (err_set) reg_d.est = 1'b1;

        hold = !act_q || !(reg_d.pwr && reg_d.srst);
        if (hold) begin
            reg_d.en  = 1'b0;
            reg_d.dst = '0;
            reg_d.est = 1'b0;
        end

        evt = (eng_done && reg_q.ie[eng_done_ch]) || (err_set && reg_q.eie);
        if (reg_d.lvl) begin
            reg_d.irq = (|(reg_d.dst & reg_d.ie)) || (reg_d.est && reg_d.eie);
        end else begin
            reg_d.irq = evt && !hold;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reg_q      <= '0;
            reg_q.cmp  <= CMP_RESET;
            reg_q.samp <= SAMP_W'(SAMP_RESET);
        end else begin
            reg_q <= reg_d;
        end
    end

    // read mux
    always_comb begin
        rdata    = '0;
        dofs     = addr - OFS_DATA;
        data_hit = (addr >= OFS_DATA) && (dofs[1:0] == 2'b00)
                   && (int'(dofs[ADDR_W-1:2]) < NUM_CH);
        case (addr)
            OFS_CTL0: rdata = {16'h0, reg_q.srst, 12'h0, reg_q.pwr, eng_busy, reg_q.en};
            OFS_CTL1: begin
                rdata[0]     = reg_q.trg;
                rdata[2]     = reg_q.sel;
                rdata[4]     = reg_q.buf1;
                rdata[8]     = reg_q.rpt;
                rdata[13:12] = reg_q.edg;
            end
            OFS_CTL2: rdata[NUM_CH-1:0] = reg_q.bmap;
            OFS_CTL3: begin
                rdata[23:16]       = reg_q.cmp;
                rdata[SAMP_W-1:0]  = reg_q.samp;
            end
            OFS_INTC: begin
                rdata[NUM_CH-1:0] = reg_q.ie;
                rdata[16]         = reg_q.eie;
                rdata[31]         = reg_q.lvl;
            end
            OFS_STAT: begin
                rdata[NUM_CH-1:0] = reg_q.dst;
                rdata[16]         = reg_q.est;
            end
            OFS_DIVR: rdata[8:0] = DIV_FIXED;
            default: begin
                if (data_hit) rdata[RES_BITS-1:0] = reg_q.data[dofs[2 +: CH_W]];
            end
        endcase
    end

    assign run_en      = reg_q.en;
    assign bitmap      = reg_q.bmap;
    assign repeat_mode = reg_q.rpt;
    assign samp_len    = reg_q.samp;
    assign active      = act_q;
    assign stat_flags  = reg_q.dst;
    assign stat_err    = reg_q.est;
    assign irq         = reg_q.irq;
endmodule

// File: rtl/sar_seq_top.sv
module sar_seq_top
    import sar_pkg::*;
#(
    parameter int NUM_CH   = 8,
    parameter int RES_BITS = 12,
    parameter int SAMP_W   = 16,
    localparam int CH_W    = $clog2(NUM_CH)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic                reg_we,
    input  logic [31:0]         reg_wdata,
    output logic [31:0]         reg_rdata,
    input  logic                cmp_in,
    output logic [RES_BITS-1:0] dac_code,
    output logic                sample_en,
    output logic [CH_W-1:0]     conv_chan,
    output logic                irq
);
    logic                run_en;
    logic                start_pulse;
    logic [NUM_CH-1:0]   bitmap;
    logic                repeat_mode;
    logic [SAMP_W-1:0]   samp_len;
    logic                regs_active;
    logic [NUM_CH-1:0]   stat_flags;
    logic                stat_err;
    logic                eng_busy;
    logic                eng_done;
    logic [CH_W-1:0]     eng_done_ch;
    logic [RES_BITS-1:0] eng_code;
    logic                eng_end;

    sar_regs #(
        .NUM_CH(NUM_CH), .RES_BITS(RES_BITS), .SAMP_W(SAMP_W)
    ) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .addr        (reg_addr),
        .we          (reg_we),
        .wdata       (reg_wdata),
        .rdata       (reg_rdata),
        .eng_busy    (eng_busy),
        .eng_done    (eng_done),
        .eng_done_ch (eng_done_ch),
        .eng_code    (eng_code),
        .eng_end     (eng_end),
        .run_en      (run_en),
        .start       (start_pulse),
        .bitmap      (bitmap),
        .repeat_mode (repeat_mode),
        .samp_len    (samp_len),
        .active      (regs_active),
        .stat_flags  (stat_flags),
        .stat_err    (stat_err),
        .irq         (irq)
    );

    sar_engine #(
        .NUM_CH(NUM_CH), .RES_BITS(RES_BITS), .SAMP_W(SAMP_W)
    ) u_engine (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start_pulse),
        .run_en      (run_en),
        .bitmap      (bitmap),
        .repeat_mode (repeat_mode),
        .samp_len    (samp_len),
        .cmp_in      (cmp_in),
        .busy        (eng_busy),
        .sample_en   (sample_en),
        .chan        (conv_chan),
        .dac_code    (dac_code),
        .done        (eng_done),
        .done_ch     (eng_done_ch),
        .done_code   (eng_code),
        .scan_end    (eng_end)
    );
endmodule

// File: rtl/sar_seq_chk.sv
module sar_seq_chk #(
    parameter int NUM_CH = 8,
    localparam int CH_W  = $clog2(NUM_CH)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              en,
    input logic              start,
    input logic              busy,
    input logic              active,
    input logic [NUM_CH-1:0] flags,
    input logic              err_flag,
    input logic [NUM_CH-1:0] bitmap,
    input logic              done,
    input logic [CH_W-1:0]   done_ch
);
    AST_ABORT_IDLES: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !start) |=> !busy);                                   // R8

    AST_GATED_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> (flags == '0 && !err_flag && !en));               // R2

    AST_EMPTY_NO_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && bitmap == '0) |=> !busy);                           // R6

    AST_DONE_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (flags[$past(done_ch)] || !active));                 // R4
endmodule

bind sar_seq_top sar_seq_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (run_en),
    .start    (start_pulse),
    .busy     (eng_busy),
    .active   (regs_active),
    .flags    (stat_flags),
    .err_flag (stat_err),
    .bitmap   (bitmap),
    .done     (eng_done),
    .done_ch  (eng_done_ch)
);

// File: tb/test_sar_seq_top.sv
module test_sar_seq_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic        reg_we = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        cmp_in;
    logic [11:0] dac_code;
    logic        sample_en;
    logic [2:0]  conv_chan;
    logic        irq;

    logic [11:0] vin [8];
    int n_chk = 0;
    int n_bad = 0;

    // monitor state
    logic mon_clr = 1'b0;
    int   run_len = 0, last_run = 0;
    int   log_n = 0;
    int   chan_log [64];
    int   irq_cnt = 0, irq_run = 0, irq_max = 0;
    logic prev_se = 1'b0;

    always #2.5 clk = ~clk;

    assign cmp_in = (vin[conv_chan] >= dac_code);

    sar_seq_top i_sar_seq_top (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cmp_in(cmp_in),
        .dac_code(dac_code), .sample_en(sample_en), .conv_chan(conv_chan), .irq(irq)
    );

    always @(negedge clk) begin
        if (mon_clr) begin
            run_len = 0; last_run = 0; log_n = 0;
            irq_cnt = 0; irq_run = 0; irq_max = 0;
        end else begin
            if (sample_en && !prev_se && log_n < 64) begin
                chan_log[log_n] = int'(conv_chan);
                log_n++;
            end
            if (sample_en) run_len++;
            else if (run_len > 0) begin last_run = run_len; run_len = 0; end
            if (irq) begin
                irq_cnt++; irq_run++;
                if (irq_run > irq_max) irq_max = irq_run;
            end else irq_run = 0;
        end
        prev_se = sample_en;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(posedge clk);
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic clr_mon();
        mon_clr = 1'b1;
        @(posedge clk);
        @(negedge clk);
        #1;
        mon_clr = 1'b0;
    endtask

    task automatic wait_idle();
        logic [31:0] v;
        for (int k = 0; k < 40000; k++) begin
            @(negedge clk);
            rd(8'h00, v);
            if (v[1:0] == 2'b00) return;
        end
    endtask

    task automatic run_scan(input logic [7:0] bm, input int samp);
        wr(8'h08, {24'h0, bm});
        wr(8'h0C, {8'h00, 8'h0E, 16'(samp)});
        wr(8'h04, 32'h0);
        clr_mon();
        @(negedge clk);
        wr(8'h00, 32'h8005);
        wait_idle();
    endtask

    function automatic int nth_set(input logic [7:0] bm, input int k);
        int c = 0;
        for (int i = 0; i < 8; i++) begin
            if (bm[i]) begin
                if (c == k) return i;
                c++;
            end
        end
        return -1;
    endfunction

    initial begin
        repeat (180000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] v;
        logic [11:0] old3;
        void'($urandom(32'h5A3C_0917));
        for (int i = 0; i < 8; i++) vin[i] = '0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset values
        rd(8'h00, v); check("R1 ctrl0", v, 32'h0);
        rd(8'h0C, v); check("R1 ctrl3", v, 32'h000E0578);
        rd(8'h28, v); check("R1 divider", v, 32'h4);
        rd(8'h24, v); check("R1 status", v, 32'h0);
        rd(8'h30, v); check("R1 data0", v, 32'h0);
        check("R1 irq", {31'h0, irq}, 32'h0);

        // R2 gating of enable while unpowered / in reset
        wr(8'h08, 32'h1);
        wr(8'h00, 32'h1);      rd(8'h00, v); check("R2 enable ignored", v, 32'h0);
        wr(8'h00, 32'h5);      rd(8'h00, v); check("R2 no reset release", v, 32'h4);
        wr(8'h00, 32'h8001);   rd(8'h00, v); check("R2 no power", v, 32'h8000);
        wr(8'h00, 32'h8004);   rd(8'h00, v); check("R2 powered", v, 32'h8004);

        // R12 / R11
        wr(8'h0C, 32'hFF0E0010); rd(8'h0C, v); check("R12 ctrl3 top byte", v, 32'h000E0010);
        wr(8'h28, 32'h7);        rd(8'h28, v); check("R11 divider fixed", v, 32'h4);

        // R3 R4 R9 directed full scan with code extremes
        vin[0] = 12'h000; vin[1] = 12'hFFF; vin[2] = 12'h800; vin[3] = 12'h7FF;
        vin[4] = 12'h001; vin[5] = 12'hAAA; vin[6] = 12'h555; vin[7] = 12'hFFE;
        run_scan(8'hFF, 3);
        for (int i = 0; i < 8; i++) begin
            rd(8'(8'h30 + 4 * i), v); check("R3 data", v, {20'h0, vin[i]});
        end
        check("R4 channel count", 32'(log_n), 32'd8);
        for (int i = 0; i < 8; i++) check("R4 order", 32'(chan_log[i]), 32'(i));
        rd(8'h24, v); check("R4 status", v, 32'hFF);
        rd(8'h00, v); check("R4 enable self-clear", v, 32'h8004);
        check("R9 sample length 3", 32'(last_run), 32'd3);

        // R7 write-one-to-clear
        wr(8'h24, 32'h0F); rd(8'h24, v); check("R7 partial clear", v, 32'hF0);
        wr(8'h24, 32'h00); rd(8'h24, v); check("R7 zero write", v, 32'hF0);
        wr(8'h24, 32'hF0); rd(8'h24, v); check("R7 full clear", v, 32'h0);

        // R9 zero sampling count
        run_scan(8'h10, 0);
        check("R9 sample length 0->1", 32'(last_run), 32'd1);
        wr(8'h24, 32'hFF);

        // R6 empty bitmap
        wr(8'h08, 32'h0);
        wr(8'h00, 32'h8005);
        rd(8'h00, v); check("R6 enable stays clear", v, 32'h8004);
        rd(8'h24, v); check("R6 error flag", v, 32'h10000);
        repeat (4) @(negedge clk);
        rd(8'h00, v); check("R6 no busy", v, 32'h8004);

        // R10 level mode, error and channel sources
        wr(8'h20, 32'h8001_0002);
        @(negedge clk); #1;
        check("R10 level error irq", {31'h0, irq}, 32'h1);
        wr(8'h24, 32'h10000);
        #1; check("R10 level error cleared", {31'h0, irq}, 32'h0);
        vin[1] = 12'h3C5;
        run_scan(8'h02, 2);
        #1; check("R10 level irq set", {31'h0, irq}, 32'h1);
        repeat (10) @(negedge clk);
        #1; check("R10 level irq held", {31'h0, irq}, 32'h1);
        wr(8'h24, 32'h02);
        #1; check("R10 level irq cleared", {31'h0, irq}, 32'h0);

        // R10 pulse mode
        wr(8'h20, 32'h0000_00FF);
        run_scan(8'h29, 2);
        repeat (2) @(negedge clk);
        check("R10 pulse count", 32'(irq_cnt), 32'd3);
        check("R10 pulse width", 32'(irq_max), 32'd1);
        wr(8'h24, 32'hFF);
        wr(8'h20, 32'h0);

        // R5 repeat mode
        wr(8'h08, 32'h05);
        wr(8'h0C, 32'h000E0002);
        wr(8'h04, 32'h100);
        clr_mon();
        wr(8'h00, 32'h8005);
        for (int k = 0; k < 2000; k++) begin
            @(negedge clk); #1;
            if (log_n >= 5) break;
        end
        rd(8'h00, v); check("R5 still enabled", {31'h0, v[0]}, 32'h1);
        check("R5 wrap 0", 32'(chan_log[0]), 32'd0);
        check("R5 wrap 1", 32'(chan_log[1]), 32'd2);
        check("R5 wrap 2", 32'(chan_log[2]), 32'd0);
        check("R5 wrap 3", 32'(chan_log[3]), 32'd2);
        check("R5 wrap 4", 32'(chan_log[4]), 32'd0);
        // R8 busy falls one clock after the enable is cleared
        wr(8'h00, 32'h8004);
        @(negedge clk);
        rd(8'h00, v); check("R8 busy falls", v, 32'h8004);
        wr(8'h04, 32'h0);
        wr(8'h24, 32'hFF);

        // R8 abandoned channel leaves no trace
        rd(8'h3C, v); old3 = v[11:0];
        vin[3] = ~old3;
        wr(8'h08, 32'h08);
        wr(8'h0C, 32'h000E0578);
        wr(8'h00, 32'h8005);
        repeat (50) @(negedge clk);
        wr(8'h00, 32'h8004);
        repeat (2) @(negedge clk);
        rd(8'h24, v); check("R8 no status", v, 32'h0);
        rd(8'h3C, v); check("R8 data kept", v, {20'h0, old3});
        rd(8'h00, v); check("R8 idle", v, 32'h8004);

        // R2 status held at zero while reset release is low
        vin[0] = 12'h123;
        run_scan(8'h01, 2);
        rd(8'h24, v); check("R2 status before", v, 32'h1);
        wr(8'h00, 32'h0004);
        rd(8'h24, v); check("R2 status held", v, 32'h0);
        wr(8'h00, 32'h8004);
        rd(8'h24, v); check("R2 status after", v, 32'h0);

        // random scans: R3 R4
        for (int it = 0; it < 20; it++) begin
            logic [7:0] bm;
            int cnt;
            bm = 8'($urandom);
            if (bm == 8'h0) bm = 8'h80;
            for (int i = 0; i < 8; i++) vin[i] = 12'($urandom);
            run_scan(bm, 1 + int'($urandom % 6));
            cnt = $countones(bm);
            check("R4 random count", 32'(log_n), 32'(cnt));
            for (int k = 0; k < cnt; k++)
                check("R4 random order", 32'(chan_log[k]), 32'(nth_set(bm, k)));
            for (int i = 0; i < 8; i++) begin
                if (bm[i]) begin
                    rd(8'(8'h30 + 4 * i), v); check("R3 random data", v, {20'h0, vin[i]});
                end
            end
            rd(8'h24, v); check("R4 random status", v, {24'h0, bm});
            wr(8'h24, 32'hFF);
        end

        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule